// File: doc/BRIEF.md
# Rotate-Through-Carry Unit

This block is the datapath of a rotate-through-carry operation, as found in an integer execution pipeline. It treats the carry flag and an operand of 1, 2, 4 or 8 bytes as one ring of W+1 bits, where W is the operand width in bits. It rotates that ring left or right by a count, and returns the low W bits of the ring as the new operand value. It does not produce flags.

The new value replaces only the operand-sized low part of the old destination register value. The bytes above the operand size keep their old contents. The count operand is masked before use. When the masked count is zero, the old destination value passes through unchanged.

A parameter selects between a purely combinational path and one output register stage with synchronous reset. In the registered variant, the default, the result of the inputs sampled at a clock edge appears on the output right after that edge.

Top module: `carry_rotator`

## Requirements
- R1: The effective count n is `count_i[3:0]` when `size_i` is 2'b11, and `count_i[2:0]` otherwise. All higher count bits are ignored.
- R2: When n is zero, `dst_o` equals `dst_old_i` on all 64 bits, whatever the direction, source and carry.
- R3: For a right rotate (`dir_left_i`=0) by n≥1 of a W-bit operand:
  - result bits W−n−1..0 are source bits W−1..n;
  - result bit W−n is the carry;
  - result bits W−1..W−n+1 are source bits n−2..0.
- R4: For a left rotate (`dir_left_i`=1) by n≥1:
  - result bits W−1..n are source bits W−n−1..0;
  - result bit n−1 is the carry;
  - result bits n−2..0 are source bits W−1..W−n+1.
- R5: The size encoding of `size_i` is:
  - 2'b00 selects 1 byte;
  - 2'b01 selects 2 bytes;
  - 2'b10 selects 4 bytes;
  - 2'b11 selects 8 bytes.

  Only the low W=8×bytes bits of `dst_o` carry the rotated result. Bits 63..W equal the same bits of `dst_old_i`, and no rotated bit leaks into them.
- R6: `dir_left_i`=1 selects a left rotate and `dir_left_i`=0 selects a right rotate. Both directions are available at every size.
- R7: In the registered variant, `dst_o` shows the result of the inputs sampled at a rising clock edge right after that edge. A synchronous reset that is high at an edge clears `dst_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| src_i | input | 64 | Source operand; only the low W bits are used |
| dst_old_i | input | 64 | Old destination value; upper bytes pass through |
| carry_i | input | 1 | Carry flag that enters the rotate ring |
| count_i | input | CNT_W (8) | Rotate count operand before masking |
| dir_left_i | input | 1 | 1 = rotate left, 0 = rotate right |
| size_i | input | 2 | Operand size select (00=1, 01=2, 10=4, 11=8 bytes) |
| dst_o | output | 64 | New destination value |

## Verification
The block holds no state apart from its output register, so any fault in the datapath shows at the port one cycle after the faulty input pattern. It can show as a wrong masked count, a wrong lane, a carry at a wrong bit, or a wrong merge mask. The bench sweeps:
- every size;
- both directions;
- every count 0 to 15, with the ignored upper count bits varied;
- both carry values, over several data patterns.

A lane-select or merge-mask fault appears at once in the upper bytes of `dst_o`. A count-mask fault appears as a result shifted by eight positions.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;

   typedef enum logic [1:0] {
      SZ_B1 = 2'b00,
      SZ_B2 = 2'b01,
      SZ_B4 = 2'b10,
      SZ_B8 = 2'b11
   } size_e;

   localparam int unsigned LANES    = 4;
   localparam int unsigned EFF_W    = 4;
   localparam int unsigned NARROW_W = 3;

   function automatic int unsigned lane_bits(input int unsigned idx);
      return 8 << idx;
   endfunction

endpackage

// File: rtl/rcr_count_mask.sv
`timescale 1ns/1ps
module rcr_count_mask
   import rcr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  size_e              size_i,
   input  logic [CNT_W-1:0]   count_i,
   output logic [EFF_W-1:0]   eff_o,
   output logic               zero_o
);

   if (CNT_W < EFF_W) begin : g_bad_cnt
      $error("rcr_count_mask: CNT_W must be at least EFF_W");
   end

   logic [EFF_W-1:0] wide_cnt;
   logic [EFF_W-1:0] narrow_cnt;

   assign wide_cnt   = count_i[EFF_W-1:0];
   assign narrow_cnt = {{(EFF_W-NARROW_W){1'b0}}, count_i[NARROW_W-1:0]};

   always_comb begin
      if (size_i == SZ_B8) eff_o = wide_cnt;
      else                 eff_o = narrow_cnt;
   end

   assign zero_o = (eff_o == '0);

endmodule

// File: rtl/rcr_lane.sv
`timescale 1ns/1ps
module rcr_lane #(
   parameter int unsigned W     = 8,
   parameter int unsigned AMT_W = 4
) (
   input  logic [W-1:0]     src_i,
   input  logic             carry_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             left_i,
   output logic [W-1:0]     res_o
);

   localparam int unsigned RING_W = W + 1;
   localparam int unsigned DBL_W  = 2 * RING_W;

   if (W < 8) begin : g_bad_w
      $error("rcr_lane: W must be at least 8");
   end

   logic [RING_W-1:0] ring;
   logic [DBL_W-1:0]  dbl;
   logic [DBL_W-1:0]  dbl_l;
   logic [DBL_W-1:0]  dbl_r;

   // Ring of carry above the operand; a doubled copy turns rotate into shift.
   assign ring  = {carry_i, src_i};
   assign dbl   = {ring, ring};
   assign dbl_l = dbl << amt_i;
   assign dbl_r = dbl >> amt_i;

   always_comb begin
      if (left_i) res_o = dbl_l[RING_W +: W];
      else        res_o = dbl_r[W-1:0];
   end

endmodule

// File: rtl/rcr_merge.sv
`timescale 1ns/1ps
module rcr_merge #(
   parameter int unsigned DW = 64
) (
   input  logic [DW-1:0] old_i,
   input  logic [DW-1:0] rot_i,
   input  logic [DW-1:0] keep_low_i,
   input  logic          bypass_i,
   output logic [DW-1:0] merged_o
);

   always_comb begin
      if (bypass_i) merged_o = old_i;
      else          merged_o = (old_i & ~keep_low_i) | (rot_i & keep_low_i);
   end

endmodule

// File: rtl/carry_rotator.sv
`timescale 1ns/1ps
module carry_rotator
   import rcr_pkg::*;
#(
   parameter int unsigned DW         = 64,
   parameter int unsigned CNT_W      = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [63:0]      src_i,
   input  logic [63:0]      dst_old_i,
   input  logic             carry_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             dir_left_i,
   input  logic [1:0]       size_i,
   output logic [63:0]      dst_o
);

   localparam int unsigned MAX_LANE = lane_bits(LANES - 1);

   if (DW != 64 || DW != MAX_LANE) begin : g_bad_dw
      $error("carry_rotator: DW must be 64 and match the widest lane");
   end
   if (CNT_W < EFF_W) begin : g_bad_cnt
      $error("carry_rotator: CNT_W too narrow");
   end

   size_e                     size_sel;
   logic [EFF_W-1:0]          eff_cnt;
   logic                      cnt_zero;
   logic [LANES-1:0][DW-1:0]  lane_res;
   logic [LANES-1:0][DW-1:0]  lane_mask;
   logic [DW-1:0]             sel_res;
   logic [DW-1:0]             sel_mask;
   logic [DW-1:0]             merged;

   assign size_sel = size_e'(size_i);

   rcr_count_mask #(.CNT_W(CNT_W)) u_cnt (
      .size_i  (size_sel),
      .count_i (count_i),
      .eff_o   (eff_cnt),
      .zero_o  (cnt_zero)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned LW = lane_bits(g);
      logic [LW-1:0] res;

      rcr_lane #(.W(LW), .AMT_W(EFF_W)) u_lane (
         .src_i   (src_i[LW-1:0]),
         .carry_i (carry_i),
         .amt_i   (eff_cnt),
         .left_i  (dir_left_i),
         .res_o   (res)
      );

      if (LW < DW) begin : g_pad
         assign lane_res[g] = {{(DW-LW){1'b0}}, res};
      end else begin : g_full
         assign lane_res[g] = res;
      end
      assign lane_mask[g] = {DW{1'b1}} >> (DW - LW);
   end

   assign sel_res  = lane_res[size_i];
   assign sel_mask = lane_mask[size_i];

   rcr_merge #(.DW(DW)) u_merge (
      .old_i      (dst_old_i),
      .rot_i      (sel_res),
      .keep_low_i (sel_mask),
      .bypass_i   (cnt_zero),
      .merged_o   (merged)
   );

   if (REGISTERED) begin : g_reg
      logic [DW-1:0] dst_q;
      always_ff @(posedge clk) begin
         if (rst) dst_q <= '0;
         else     dst_q <= merged;
      end
      assign dst_o = dst_q;
   end else begin : g_comb
      assign dst_o = merged;
   end

endmodule

// File: rtl/carry_rotator_chk.sv
`timescale 1ns/1ps
module carry_rotator_chk #(
   parameter int unsigned CNT_W      = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic [63:0]      src_i,
   input logic [63:0]      dst_old_i,
   input logic             carry_i,
   input logic [CNT_W-1:0] count_i,
   input logic             dir_left_i,
   input logic [1:0]       size_i,
   input logic [63:0]      dst_o
);

   logic [3:0] n_chk;
   assign n_chk = (size_i == 2'b11) ? count_i[3:0] : {1'b0, count_i[2:0]};

   if (REGISTERED) begin : g_seq
      assert_reset_clear_R7: assert property (@(posedge clk)
         rst |=> dst_o == 64'd0);

      assert_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
         n_chk == 4'd0 |=> dst_o == $past(dst_old_i));

      assert_wide_mask_R1: assert property (@(posedge clk) disable iff (rst)
         (size_i == 2'b11 && count_i[3:0] == 4'd8 && dir_left_i)
         |=> dst_o[7] == $past(carry_i));

      assert_right_carry_R3: assert property (@(posedge clk) disable iff (rst)
         (size_i == 2'b11 && n_chk == 4'd1 && !dir_left_i)
         |=> dst_o == {$past(carry_i), $past(src_i[63:1])});

      assert_left_carry_R4: assert property (@(posedge clk) disable iff (rst)
         (size_i == 2'b00 && n_chk == 4'd1 && dir_left_i)
         |=> dst_o[7:0] == {$past(src_i[6:0]), $past(carry_i)});

      assert_upper_b1_R5: assert property (@(posedge clk) disable iff (rst)
         size_i == 2'b00 |=> dst_o[63:8] == $past(dst_old_i[63:8]));

      assert_upper_b2_R5: assert property (@(posedge clk) disable iff (rst)
         size_i == 2'b01 |=> dst_o[63:16] == $past(dst_old_i[63:16]));

      assert_upper_b4_R5: assert property (@(posedge clk) disable iff (rst)
         size_i == 2'b10 |=> dst_o[63:32] == $past(dst_old_i[63:32]));
   end

endmodule

bind carry_rotator carry_rotator_chk #(
   .CNT_W      (CNT_W),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .src_i      (src_i),
   .dst_old_i  (dst_old_i),
   .carry_i    (carry_i),
   .count_i    (count_i),
   .dir_left_i (dir_left_i),
   .size_i     (size_i),
   .dst_o      (dst_o)
);

// File: tb/carry_rotator_bench.sv
`timescale 1ns/1ps
module carry_rotator_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] src_i = '0;
   logic [63:0] dst_old_i = '0;
   logic        carry_i = 1'b0;
   logic [7:0]  count_i = '0;
   logic        dir_left_i = 1'b0;
   logic [1:0]  size_i = '0;
   logic [63:0] dst_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   carry_rotator u_carry_rotator (
      .clk        (clk),
      .rst        (rst),
      .src_i      (src_i),
      .dst_old_i  (dst_old_i),
      .carry_i    (carry_i),
      .count_i    (count_i),
      .dir_left_i (dir_left_i),
      .size_i     (size_i),
      .dst_o      (dst_o)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] width_mask(input logic [1:0] sz);
      int w = 8 << sz;
      return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
   endfunction

   // Bit-by-bit rotation of the (W+1)-bit ring {carry, operand}.
   function automatic logic [63:0] model(input logic [63:0] src, input logic [63:0] old,
                                         input logic c, input logic [7:0] cnt,
                                         input logic left, input logic [1:0] sz);
      int          w  = 8 << sz;
      int          n  = (sz == 2'b11) ? int'(cnt[3:0]) : int'(cnt[2:0]);
      logic [63:0] m  = width_mask(sz);
      logic [63:0] v  = src & m;
      logic        cc = c;
      logic        nc;
      if (n == 0) return old;
      for (int i = 0; i < n; i++) begin
         if (left) begin
            nc = v[w-1];
            v  = ((v << 1) | {63'd0, cc}) & m;
         end else begin
            nc = v[0];
            v  = (v >> 1) | ({63'd0, cc} << (w - 1));
         end
         cc = nc;
      end
      return (old & ~m) | v;
   endfunction

   task automatic apply(input logic [63:0] src, input logic [63:0] old, input logic c,
                        input logic [7:0] cnt, input logic left, input logic [1:0] sz);
      logic [63:0] exp;
      int          n;
      string       tag;
      @(negedge clk);
      src_i = src; dst_old_i = old; carry_i = c;
      count_i = cnt; dir_left_i = left; size_i = sz;
      exp = model(src, old, c, cnt, left, sz);
      n   = (sz == 2'b11) ? int'(cnt[3:0]) : int'(cnt[2:0]);
      if (n == 0)    tag = "R2";
      else if (left) tag = "R4/R6";
      else           tag = "R3/R6";
      if (int'(cnt) != n) tag = {"R1 ", tag};
      @(posedge clk);
      #2;
      check(tag, dst_o, exp);
      if (sz != 2'b11)
         check("R5 upper bytes", dst_o & ~width_mask(sz), old & ~width_mask(sz));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      logic [63:0] srcs [3];
      logic [63:0] olds [3];
      srcs[0] = 64'h8000_0000_0000_0001; olds[0] = 64'hFFFF_FFFF_FFFF_FFFF;
      srcs[1] = 64'hA5C3_0F96_3CE1_7B2D; olds[1] = 64'h1234_5678_9ABC_DEF0;
      srcs[2] = 64'h0123_4567_89AB_CDEF; olds[2] = 64'h0000_0000_0000_0000;

      repeat (3) @(posedge clk);
      #2;
      check("R7 reset state", dst_o, 64'd0);
      @(negedge clk);
      rst = 1'b0;

      for (int p = 0; p < 3; p++)
         for (int sz = 0; sz < 4; sz++)
            for (int d = 0; d < 2; d++)
               for (int c = 0; c < 2; c++)
                  for (int k = 0; k < 16; k++)
                     apply(srcs[p], olds[p], c[0], 8'(k + 16 * ((k + p) % 5)), d[0], sz[1:0]);

      // R7: synchronous reset in mid-run clears the registered output
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      check("R7 mid-run reset", dst_o, 64'd0);
      @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
      finish_run();
   end

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R7 watchdog expired got %h exp %h", 64'd0, 64'd1);
         finish_run();
      end
   end

endmodule